// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a single-beat request port on an internal synchronous bus and an external asynchronous static RAM of 512K words by 24 bits. The RAM's 24-bit word is split into three 8-bit lanes, and each lane has its own active-low select. There is no shared chip enable and no separate byte-enable pin. The controller turns each accepted request into a registered sequence on the address pins, the three lane selects, write enable and output enable. It also drives the output-enable control of its own data bus, and for reads it captures the returned word and hands it back with a one-cycle valid pulse.

Every analog timing limit is turned into a whole number of clock cycles at elaboration, from the clock period and the limit in picoseconds, rounded up to at least one cycle. A mode parameter selects how output enable behaves during writes:

- It can rise for the whole write.
- It can stay low through the write. In that mode the RAM may still drive the bus for a while after write enable falls, so the controller holds off its own drive for that hand-over time.

After reset the controller refuses requests until a power-up interval has passed.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is high and afterwards until the power-up count ends, req_ready is low, all lane selects, write enable and output enable are high, and the data bus is not driven. req_ready first rises exactly N_PWR = ceil(T_PWR_PS/CLK_PS) cycles after the first clock edge that sees reset low.
- R2: A write pulls low only the selects whose req_mask bit is set (bit 0 selects data bits 7:0, bit 1 bits 15:8, bit 2 bits 23:16). Lanes whose mask bit is clear keep their stored contents. A mask of zero stores nothing.
- R3: Write enable stays low for N_WE = max(N_WP, D + N_SD) cycles. D is the drive hold-off (N_HZ when output enable stays low during writes, otherwise 0). The data is driven for at least N_SD cycles before the write ends. req_ready returns N_WE + 2 cycles after the accepting edge, counted as falling clock edges.
- R4: The controller never drives the data bus in a cycle where the RAM may drive it. After a write, the data is held for one cycle with all strobes high and is then released.
- R5: A read holds the masked selects low, write enable high and output enable low for N_AA = ceil(max(T_AA_PS, T_DOE_PS)/CLK_PS) cycles. The word is captured at the edge that ends that window. rsp_valid is high for exactly one cycle, N_AA + 1 falling edges after acceptance. Lanes not selected return zero.
- R6: With OE_IN_WRITE = 1, output enable stays low during the write, and the bus is not driven for the first N_HZ cycles of write enable low. With OE_IN_WRITE = 0, output enable is high whenever write enable is low, and the data is driven from the first write cycle.
- R7: When output enable falls for a read, the data bus was not driven in the cycle before.
- R8: The address pins change only in the cycle after a request is accepted, so they stay constant through each access and its write hold cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and powered up; request accepted when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 8*LANES | Write data |
| req_mask | input | LANES | Per-lane enable, bit n for bits 8n+7:8n |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 8*LANES | Read data, zero in lanes not selected |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_cs_n | output | LANES | Active-low lane selects |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8*LANES | Data to the pad drivers |
| mem_dq_oe | output | 1 | Pad driver enable for the data bus |
| mem_dq_in | input | 8*LANES | Data from the pads |

## Verification
Several things can coincide in one cycle:

- In the low-output-enable mode, the start of a write makes the RAM's lingering drive and the controller's own drive candidates for the same cycle.
- A read accepted at the first idle cycle after a write brings the release of the write data and the fall of output enable within a cycle of each other.

Both cases are provoked by issuing every partial-mask write followed at once by a read of the same word, on two instances that differ only in the write mode. The bench's RAM model flags any cycle where both sides drive. It returns filler data until the access time has elapsed and stores a poison byte when the pulse width or data setup is short. As a result, a wrong overlap, a premature capture or a shortened strobe shows up as a read-back mismatch or a nonzero violation count.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int unsigned LANE_BITS = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_WREC  = 2'd2,
        ST_READ  = 2'd3
    } seq_state_e;

    // Values the pin registers take on the next clock edge
    typedef struct packed {
        logic sel;      // selects of masked lanes go low
        logic we_n;
        logic oe_n;
        logic drive;    // own data bus output enable
    } strobe_t;

    function automatic int unsigned cyc_ceil(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_pwr_hold.sv
module sram_pwr_hold #(
    parameter int unsigned N_PWR = 1
) (
    input  logic clk,
    input  logic rst,
    output logic done
);
    localparam int CW = $clog2(N_PWR + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == CW'(N_PWR - 1)) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned LANES       = 3,
    parameter int unsigned N_WE        = 1,
    parameter int unsigned N_DRV       = 0,
    parameter int unsigned N_RD        = 1,
    parameter bit          OE_IN_WRITE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_done,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LANES-1:0] req_mask,
    output logic             req_ready,
    output logic             load,
    output strobe_t          strb_nxt,
    output logic [LANES-1:0] mask_nxt,
    output logic [LANES-1:0] mask_q,
    output logic             cap_en
);
    localparam int unsigned CNT_MAX = max2(N_WE, N_RD);
    localparam int          CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_e       st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             drv_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            mask_q <= '0;
        end else begin
            st     <= st_n;
            cnt    <= cnt_n;
            mask_q <= mask_nxt;
        end
    end

    assign req_ready = (st == ST_IDLE) && pwr_done;
    assign mask_nxt  = load ? req_mask : mask_q;
    assign cap_en    = (st == ST_READ) && (cnt == CNT_W'(N_RD - 1));

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        load  = 1'b0;
        case (st)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    load  = 1'b1;
                    cnt_n = '0;
                    st_n  = req_write ? ST_WRITE : ST_READ;
                end
            end
            ST_WRITE: begin
                if (cnt == CNT_W'(N_WE - 1)) begin
                    st_n = ST_WREC;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_WREC: begin
                st_n = ST_IDLE;
            end
            ST_READ: begin
                if (cnt == CNT_W'(N_RD - 1)) begin
                    st_n = ST_IDLE;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Drive hold-off while the RAM may still own the bus
    generate
        if (N_DRV == 0) begin : g_drv_now
            assign drv_ok = 1'b1;
        end else begin : g_drv_late
            assign drv_ok = (cnt_n >= CNT_W'(N_DRV));
        end
    endgenerate

    always_comb begin
        strb_nxt.sel   = 1'b0;
        strb_nxt.we_n  = 1'b1;
        strb_nxt.oe_n  = 1'b1;
        strb_nxt.drive = 1'b0;
        case (st_n)
            ST_WRITE: begin
                strb_nxt.sel   = 1'b1;
                strb_nxt.we_n  = 1'b0;
                strb_nxt.oe_n  = !OE_IN_WRITE;
                strb_nxt.drive = drv_ok;
            end
            ST_WREC: begin
                strb_nxt.drive = 1'b1;
            end
            ST_READ: begin
                strb_nxt.sel   = 1'b1;
                strb_nxt.oe_n  = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned LANES  = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [LANES*LANE_BITS-1:0] req_wdata,
    input  strobe_t                    strb_nxt,
    input  logic [LANES-1:0]           mask_nxt,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [LANES-1:0]           mem_cs_n,
    output logic                       mem_we_n,
    output logic                       mem_oe_n,
    output logic [LANES*LANE_BITS-1:0] mem_dq_out,
    output logic                       mem_dq_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr  <= '0;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            if (load) begin
                mem_addr <= req_addr;
            end
            mem_we_n  <= strb_nxt.we_n;
            mem_oe_n  <= strb_nxt.oe_n;
            mem_dq_oe <= strb_nxt.drive;
        end
    end

    generate
        for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem_cs_n[g]                          <= 1'b1;
                    mem_dq_out[g*LANE_BITS +: LANE_BITS] <= '0;
                end else begin
                    mem_cs_n[g] <= ~(strb_nxt.sel & mask_nxt[g]);
                    if (load) begin
                        mem_dq_out[g*LANE_BITS +: LANE_BITS] <= req_wdata[g*LANE_BITS +: LANE_BITS];
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned LANES = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cap_en,
    input  logic [LANES-1:0]           mask_q,
    input  logic [LANES*LANE_BITS-1:0] mem_dq_in,
    output logic                       rsp_valid,
    output logic [LANES*LANE_BITS-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= cap_en;
        end
    end

    generate
        for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    rsp_rdata[g*LANE_BITS +: LANE_BITS] <= '0;
                end else if (cap_en) begin
                    rsp_rdata[g*LANE_BITS +: LANE_BITS] <=
                        mask_q[g] ? mem_dq_in[g*LANE_BITS +: LANE_BITS] : '0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 19,
    parameter int unsigned LANES       = 3,
    parameter int unsigned CLK_PS      = 20000,
    parameter int unsigned T_WP_PS     = 6000,
    parameter int unsigned T_SD_PS     = 5000,
    parameter int unsigned T_AA_PS     = 8000,
    parameter int unsigned T_DOE_PS    = 5000,
    parameter int unsigned T_HZWE_PS   = 5000,
    parameter int unsigned T_PWR_PS    = 1000000000,
    parameter bit          OE_IN_WRITE = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [LANES*LANE_BITS-1:0] req_wdata,
    input  logic [LANES-1:0]           req_mask,
    output logic                       rsp_valid,
    output logic [LANES*LANE_BITS-1:0] rsp_rdata,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [LANES-1:0]           mem_cs_n,
    output logic                       mem_we_n,
    output logic                       mem_oe_n,
    output logic [LANES*LANE_BITS-1:0] mem_dq_out,
    output logic                       mem_dq_oe,
    input  logic [LANES*LANE_BITS-1:0] mem_dq_in
);
    localparam int unsigned N_WP  = cyc_ceil(T_WP_PS, CLK_PS);
    localparam int unsigned N_SD  = cyc_ceil(T_SD_PS, CLK_PS);
    localparam int unsigned N_HZ  = cyc_ceil(T_HZWE_PS, CLK_PS);
    localparam int unsigned N_AA  = max2(cyc_ceil(T_AA_PS, CLK_PS), cyc_ceil(T_DOE_PS, CLK_PS));
    localparam int unsigned N_PWR = cyc_ceil(T_PWR_PS, CLK_PS);
    localparam int unsigned N_DRV = OE_IN_WRITE ? N_HZ : 0;
    localparam int unsigned N_WE  = max2(N_WP, N_DRV + N_SD);

    logic             pwr_done;
    logic             load;
    logic             cap_en;
    strobe_t          strb_nxt;
    logic [LANES-1:0] mask_nxt;
    logic [LANES-1:0] mask_q;

    sram_pwr_hold #(.N_PWR(N_PWR)) u_pwr (
        .clk  (clk),
        .rst  (rst),
        .done (pwr_done)
    );

    sram_access_seq #(
        .LANES       (LANES),
        .N_WE        (N_WE),
        .N_DRV       (N_DRV),
        .N_RD        (N_AA),
        .OE_IN_WRITE (OE_IN_WRITE)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pwr_done  (pwr_done),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_mask  (req_mask),
        .req_ready (req_ready),
        .load      (load),
        .strb_nxt  (strb_nxt),
        .mask_nxt  (mask_nxt),
        .mask_q    (mask_q),
        .cap_en    (cap_en)
    );

    sram_pin_regs #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .strb_nxt   (strb_nxt),
        .mask_nxt   (mask_nxt),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

    sram_read_capture #(.LANES(LANES)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .mask_q    (mask_q),
        .mem_dq_in (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int unsigned ADDR_W      = 19,
    parameter int unsigned LANES       = 3,
    parameter bit          OE_IN_WRITE = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    // R1: an idle controller leaves every strobe inactive
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> ((&mem_cs_n) && mem_we_n && mem_oe_n && !mem_dq_oe));

    // R4: own drive never overlaps a cycle where the RAM may output
    p_no_clash_r4: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (mem_oe_n || !mem_we_n || (&mem_cs_n)));

    // R5: read data valid is a single-cycle pulse
    p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R6: output enable stays high during writes in the default mode
    p_oe_high_wr_r6: assert property (@(posedge clk) disable iff (rst)
        ((OE_IN_WRITE == 1'b0) && !mem_we_n) |-> mem_oe_n);

    // R7: bus released at least one cycle before a read turns output enable on
    p_turn_gap_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_oe_n) && mem_we_n) |-> !$past(mem_dq_oe));

    // R8: address moves only after an accepted request
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> $past(req_valid && req_ready));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W      (ADDR_W),
    .LANES       (LANES),
    .OE_IN_WRITE (OE_IN_WRITE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_async_model.sv
module sram_async_model #(
    parameter int N_WP = 1,
    parameter int N_SD = 1,
    parameter int N_AA = 1,
    parameter int N_HZ = 1
) (
    input  logic        clk,
    input  logic [18:0] addr,
    input  logic [2:0]  cs_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [23:0] dq_out,
    input  logic        dq_oe,
    output logic [23:0] dq_in,
    output int          clash_cnt,
    output int          setup_viol,
    output int          gap_viol,
    output int          addr_viol
);
    logic [23:0] mem [int];
    logic [23:0] dq_r = 24'h5A5A5A;
    int c_clash = 0;
    int c_setup = 0;
    int c_gap   = 0;
    int c_addr  = 0;
    int we_low  = 0;
    int rd_run  = 0;
    int pulse [3] = '{default: 0};
    int setup [3] = '{default: 0};
    logic [7:0]  dat [3] = '{default: 8'h00};
    logic        act_prev [3] = '{default: 1'b0};
    logic        prev_oe_n = 1'b1;
    logic        prev_dq_oe = 1'b0;
    logic        prev_active = 1'b0;
    logic [18:0] prev_addr = '0;

    assign dq_in      = dq_r;
    assign clash_cnt  = c_clash;
    assign setup_viol = c_setup;
    assign gap_viol   = c_gap;
    assign addr_viol  = c_addr;

    always @(negedge clk) begin
        logic        any_sel;
        logic        ram_drive;
        logic        act;
        logic [23:0] word;
        any_sel = ~&cs_n;
        we_low  = we_n ? 0 : we_low + 1;
        // RAM may keep driving for N_HZ cycles after write enable falls
        ram_drive = any_sel && !oe_n && (we_n || we_low <= N_HZ);
        if (ram_drive && dq_oe) c_clash++;
        if (!oe_n && prev_oe_n && we_n && prev_dq_oe) c_gap++;
        if (prev_active && (any_sel || !we_n) && addr != prev_addr) c_addr++;
        word = mem.exists(int'(addr)) ? mem[int'(addr)] : 24'h000000;
        for (int l = 0; l < 3; l++) begin
            act = !cs_n[l] && !we_n;
            if (act) begin
                pulse[l]++;
                if (dq_oe) begin
                    setup[l]++;
                    dat[l] = dq_out[l*8 +: 8];
                end else begin
                    setup[l] = 0;
                end
            end else if (act_prev[l]) begin
                if (pulse[l] >= N_WP && setup[l] >= N_SD) begin
                    word[l*8 +: 8] = dat[l];
                end else begin
                    word[l*8 +: 8] = 8'hBD;
                    c_setup++;
                end
                pulse[l] = 0;
                setup[l] = 0;
            end
            act_prev[l] = act;
        end
        mem[int'(addr)] = word;
        rd_run = (any_sel && we_n && !oe_n) ? rd_run + 1 : 0;
        for (int l = 0; l < 3; l++) begin
            dq_r[l*8 +: 8] = (!cs_n[l] && we_n && !oe_n && rd_run >= N_AA) ? word[l*8 +: 8] : 8'h5A;
        end
        prev_oe_n   = oe_n;
        prev_dq_oe  = dq_oe;
        prev_active = any_sel || !we_n;
        prev_addr   = addr;
    end
endmodule

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctrl;
    localparam int CLK_PS = 20000;
    localparam int N_WP   = 3;   // 50000 ps
    localparam int N_SD   = 2;   // 30000 ps
    localparam int N_AA   = 4;   // 70000 ps
    localparam int N_HZ   = 2;   // 30000 ps
    localparam int N_PWR  = 100; // 2000000 ps
    localparam int N_WE_A = (N_WP > N_HZ + N_SD) ? N_WP : N_HZ + N_SD;
    localparam int N_WE_B = (N_WP > N_SD) ? N_WP : N_SD;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        vld_a = 1'b0, vld_b = 1'b0;
    logic        wr = 1'b0;
    logic [18:0] addr = '0;
    logic [23:0] wdat = '0;
    logic [2:0]  msk = '0;

    logic        rdy_a, rdy_b, rv_a, rv_b, we_a, we_b, oe_a, oe_b, dqoe_a, dqoe_b;
    logic [23:0] rd_a, rd_b, dqo_a, dqo_b, dqi_a, dqi_b;
    logic [18:0] ma_a, ma_b;
    logic [2:0]  cs_a, cs_b;
    int clash_a, clash_b, setv_a, setv_b, gap_a, gap_b, adv_a, adv_b;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    sram_lane_ctrl #(
        .CLK_PS(CLK_PS), .T_WP_PS(50000), .T_SD_PS(30000), .T_AA_PS(70000),
        .T_DOE_PS(5000), .T_HZWE_PS(30000), .T_PWR_PS(2000000), .OE_IN_WRITE(1'b1)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(vld_a), .req_ready(rdy_a), .req_write(wr),
        .req_addr(addr), .req_wdata(wdat), .req_mask(msk), .rsp_valid(rv_a), .rsp_rdata(rd_a),
        .mem_addr(ma_a), .mem_cs_n(cs_a), .mem_we_n(we_a), .mem_oe_n(oe_a),
        .mem_dq_out(dqo_a), .mem_dq_oe(dqoe_a), .mem_dq_in(dqi_a)
    );

    sram_lane_ctrl #(
        .CLK_PS(CLK_PS), .T_WP_PS(50000), .T_SD_PS(30000), .T_AA_PS(70000),
        .T_DOE_PS(5000), .T_HZWE_PS(30000), .T_PWR_PS(2000000), .OE_IN_WRITE(1'b0)
    ) dut_oeh (
        .clk(clk), .rst(rst), .req_valid(vld_b), .req_ready(rdy_b), .req_write(wr),
        .req_addr(addr), .req_wdata(wdat), .req_mask(msk), .rsp_valid(rv_b), .rsp_rdata(rd_b),
        .mem_addr(ma_b), .mem_cs_n(cs_b), .mem_we_n(we_b), .mem_oe_n(oe_b),
        .mem_dq_out(dqo_b), .mem_dq_oe(dqoe_b), .mem_dq_in(dqi_b)
    );

    sram_async_model #(.N_WP(N_WP), .N_SD(N_SD), .N_AA(N_AA), .N_HZ(N_HZ)) ram_a (
        .clk(clk), .addr(ma_a), .cs_n(cs_a), .we_n(we_a), .oe_n(oe_a), .dq_out(dqo_a),
        .dq_oe(dqoe_a), .dq_in(dqi_a), .clash_cnt(clash_a), .setup_viol(setv_a),
        .gap_viol(gap_a), .addr_viol(adv_a)
    );

    sram_async_model #(.N_WP(N_WP), .N_SD(N_SD), .N_AA(N_AA), .N_HZ(N_HZ)) ram_b (
        .clk(clk), .addr(ma_b), .cs_n(cs_b), .we_n(we_b), .oe_n(oe_b), .dq_out(dqo_b),
        .dq_oe(dqoe_b), .dq_in(dqi_b), .clash_cnt(clash_b), .setup_viol(setv_b),
        .gap_viol(gap_b), .addr_viol(adv_b)
    );

    wire        rdy  = sel ? rdy_b : rdy_a;
    wire        rv   = sel ? rv_b : rv_a;
    wire [23:0] rd   = sel ? rd_b : rd_a;
    wire [2:0]  cs   = sel ? cs_b : cs_a;
    wire        we   = sel ? we_b : we_a;
    wire        oe   = sel ? oe_b : oe_a;
    wire        dqoe = sel ? dqoe_b : dqoe_a;

    task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s dut=%0d actual=%h expected=%h", req, sel, act, exp);
        end
    endtask

    function automatic logic [23:0] lane_bits(input logic [2:0] m);
        return {{8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    endfunction

    function automatic logic [23:0] base_word(input int i);
        return 24'(24'h13579B + i * 24'h0A1B2C);
    endfunction

    function automatic logic [18:0] addr_of(input int i);
        return 19'(i * 19'h0C4D1 + 19'h00123);
    endfunction

    // Called at a falling edge; returns at the falling edge after acceptance
    task automatic issue(input logic w, input logic [18:0] a, input logic [23:0] d, input logic [2:0] m);
        wr = w; addr = a; wdat = d; msk = m;
        if (sel) vld_b = 1'b1; else vld_a = 1'b1;
        while (!rdy) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        vld_a = 1'b0; vld_b = 1'b0;
    endtask

    task automatic do_write(input logic [18:0] a, input logic [23:0] d, input logic [2:0] m);
        int n;
        int exp_n;
        issue(1'b1, a, d, m);
        n = 1;
        // R2: only masked lanes selected
        chk(cs == ~m, "R2 lane selects on write", {21'd0, cs}, {21'd0, ~m});
        // R6: output enable and drive hold-off in the first write cycle
        chk(we == 1'b0 && oe == sel && dqoe == sel, "R6 write start strobes",
            {21'd0, we, oe, dqoe}, {21'd0, 1'b0, sel, sel});
        while (!rdy) begin
            @(negedge clk);
            n++;
        end
        exp_n = (sel ? N_WE_B : N_WE_A) + 2;
        chk(n == exp_n, "R3 write latency", 24'(n), 24'(exp_n));
    endtask

    task automatic do_read(input logic [18:0] a, input logic [2:0] m, input logic [23:0] exp);
        int n;
        issue(1'b0, a, 24'h0, m);
        n = 1;
        chk(cs == ~m && we && !oe && !dqoe, "R5 read strobes",
            {17'd0, cs, we, oe, dqoe}, {17'd0, ~m, 1'b1, 1'b0, 1'b0});
        while (!rv) begin
            @(negedge clk);
            n++;
            if (n > 50) break;
        end
        chk(n == N_AA + 1, "R5 read latency", 24'(n), 24'(N_AA + 1));
        chk(rd == exp, "R5 read data", rd, exp);
        @(negedge clk);
        chk(!rv, "R5 valid pulse width", {23'd0, rv}, 24'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [23:0] cur [8];
        repeat (3) @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            sel = s[0];
            #1;
            chk(!rdy && (&cs) && we && oe && !dqoe, "R1 reset state",
                {19'd0, rdy, cs, we}, {19'd0, 1'b0, 3'b111, 1'b1});
        end
        sel = 1'b0;
        rst = 1'b0;
        n = 0;
        while (!rdy_a && n < 1000) begin
            @(negedge clk);
            n++;
            if (n < N_PWR) begin
                chk(!rdy_b && (&cs_a) && (&cs_b), "R1 held during power-up",
                    {21'd0, rdy_b, rdy_a, 1'b0}, 24'd0);
            end
        end
        chk(n == N_PWR, "R1 power-up count", 24'(n), 24'(N_PWR));
        chk(rdy_b, "R1 power-up both modes", {23'd0, rdy_b}, 24'd1);

        for (int s = 0; s < 2; s++) begin
            sel = s[0];
            for (int i = 0; i < 8; i++) begin
                cur[i] = base_word(i);
                do_write(addr_of(i), cur[i], 3'b111);
            end
            // partial writes, each followed at once by a full read (R2, R4, R7)
            for (int m = 0; m < 8; m++) begin
                logic [23:0] nw;
                logic [23:0] lm;
                nw = ~cur[m] ^ 24'(m * 24'h010101);
                lm = lane_bits(3'(m));
                cur[m] = (nw & lm) | (cur[m] & ~lm);
                do_write(addr_of(m), nw, 3'(m));
                do_read(addr_of(m), 3'b111, cur[m]);
                chk(cur[m] == rd, "R2 merged word after partial write", rd, cur[m]);
            end
            // masked reads of one word
            for (int r = 0; r < 8; r++) begin
                do_read(addr_of(5), 3'(r), cur[5] & lane_bits(3'(r)));
            end
            // mask zero write leaves the word untouched
            do_write(addr_of(2), 24'hFFFFFF, 3'b000);
            do_read(addr_of(2), 3'b111, cur[2]);
        end

        sel = 1'b0;
        chk(clash_a == 0, "R4 bus contention low-OE mode", 24'(clash_a), 24'd0);
        chk(setv_a == 0, "R3 pulse/setup low-OE mode", 24'(setv_a), 24'd0);
        chk(gap_a == 0, "R7 turnaround low-OE mode", 24'(gap_a), 24'd0);
        chk(adv_a == 0, "R8 address hold low-OE mode", 24'(adv_a), 24'd0);
        sel = 1'b1;
        chk(clash_b == 0, "R4 bus contention high-OE mode", 24'(clash_b), 24'd0);
        chk(setv_b == 0, "R3 pulse/setup high-OE mode", 24'(setv_b), 24'd0);
        chk(gap_b == 0, "R7 turnaround high-OE mode", 24'(gap_b), 24'd0);
        chk(adv_b == 0, "R8 address hold high-OE mode", 24'(adv_b), 24'd0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule